// File: doc/BRIEF.md
# Dispatch group admission controller

This block sits between a queue of decoded instructions and the out-of-order back end. Each cycle it looks at up to `DW` instructions at the head of the queue, oldest in lane 0, and admits the longest run of them that fits into one dispatch group. An instruction is admitted only if the group still has micro-op room and four kinds of resource are free for it: reorder-buffer entries, physical rename registers, an entry in the scheduler buffer it targets, and a load-queue or store-queue slot when it is a memory access. Admission always stops at the first instruction that does not fit, so program order is never broken.

Occupancy of every resource is tracked inside the block. The surrounding pipeline hands credits back on count inputs when instructions retire, or, for scheduler entries, when they issue. The block also profiles itself. One counter per stall reason charges each cycle in which the head of the remaining queue was held back by that reason. A histogram counts cycles by the number of micro-ops that were dispatched in them.

The instruction interface is valid/ready, one pair per lane. Valid lanes must form a contiguous run from lane 0. `in_ready[i]` is computed in the same cycle from that cycle's inputs and from the block's registered state. It is only high where `in_valid[i]` is high. The set of ready lanes is always a prefix of the valid lanes. A lane is dispatched when valid and ready are both high at a rising clock edge. A lane that is not ready must hold its instruction, and it is offered again in the next cycle.

Top module: `dispatch_admit_ctrl`

## Requirements
- R1: The dispatched lanes always form a prefix starting at lane 0; an instruction behind a blocked one is never dispatched in that cycle.
- R2: An instruction joins the group only while the group's micro-op total is below the effective width and adding its micro-ops keeps the total at or below that width; the first instruction of a cycle is admitted even when its own count exceeds the width, and the group then holds it alone.
- R3: `cfg_width` of 0 selects the parameter `DW` as the effective width; a value above `DW` is clamped to `DW`.
- R4: An instruction needs as many free reorder-buffer entries (out of `ROB_DEPTH`) as it has micro-ops.
- R5: An instruction needs as many free rename registers as it has destinations, out of `cfg_prf_size`; a size of 0 means there is no limit.
- R6: An instruction takes one entry of the scheduler buffer named by `in_sched`, each holding `SCHED_DEPTH` entries; a full buffer blocks it. Ids must be below `NSCHED`.
- R7: A load (`in_load`) needs a free load-queue slot and a store (`in_store`) a free store-queue slot, each queue holding 8 by default.
- R8: An instruction flagged `in_solo` can only open a group, and nothing joins a group that already holds one.
- R9: When the first unadmitted valid instruction is held back for a reason other than group width, exactly one stall counter increments. It is chosen by the first failing check in this order: group restriction, register, reorder buffer, scheduler, load queue, store queue. The counter indices are 0 register, 1 reorder buffer, 2 scheduler, 3 load queue, 4 store queue, 5 group restriction. A full group or an empty input charges nothing.
- R10: Every cycle, exactly one histogram bin increments, at index min(micro-ops dispatched, `DW`).
- R11: A credit returned on `rob_ret`, `reg_ret`, `sched_ret`, `lq_ret` or `sq_ret` frees its resource for admission from the following cycle, not the cycle of the return.
- R12: After reset all occupancies and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | $clog2(DW+1) | Dispatch width, 0 selects DW |
| cfg_prf_size | input | PRF_W | Rename register count, 0 unlimited |
| in_valid | input | DW | Lane holds an instruction, lane 0 oldest |
| in_ready | output | DW | Lane is dispatched this cycle |
| in_uops | input | DW x UOP_W | Micro-op count per lane |
| in_dsts | input | DW x DST_W | Destination register count per lane |
| in_sched | input | DW x SID_W | Target scheduler buffer per lane |
| in_load | input | DW | Lane is a load |
| in_store | input | DW | Lane is a store |
| in_solo | input | DW | Lane must be alone in its group |
| rob_ret | input | ROBC_W | Reorder-buffer entries freed |
| reg_ret | input | RGC_W | Rename registers freed |
| sched_ret | input | NSCHED | One entry freed per scheduler buffer |
| lq_ret | input | LQC_W | Load-queue slots freed |
| sq_ret | input | SQC_W | Store-queue slots freed |
| stall_cnt | output | 6 x CNT_W | Stall counters by reason |
| hist_cnt | output | (DW+1) x CNT_W | Cycles by micro-ops dispatched |

## Verification
The delicate overlap is a credit return landing in the same cycle as a blocked admission that needs that credit. The bench fills the reorder buffer and then a scheduler buffer. It returns one credit while the blocked instruction is still offered and checks that `in_ready` stays low in that cycle and that the stall counter charges it again. In the following cycle the same instruction must be accepted. A second overlap is two failing checks on one instruction: a full reorder buffer together with a register shortfall must charge only the register counter.

// File: rtl/dga_pkg.sv
package dga_pkg;
  typedef enum logic [2:0] {
    CZ_REG   = 3'd0,
    CZ_ROB   = 3'd1,
    CZ_SCHED = 3'd2,
    CZ_LQ    = 3'd3,
    CZ_SQ    = 3'd4,
    CZ_GROUP = 3'd5,
    CZ_NONE  = 3'd7
  } cause_e;
  localparam int NCAUSE = 6;
endpackage

// File: rtl/dga_occ.sv
// Occupancy counter for one credit-managed resource.
module dga_occ #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] take,
  input  logic [W-1:0] give,
  output logic [W-1:0] used
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used <= '0;
    else        used <= used + take - give;
  end
endmodule

// File: rtl/dga_admit.sv
// Combinational in-order admission walk over the head lanes.
module dga_admit import dga_pkg::*; #(
  parameter int LANES       = 4,
  parameter int UOP_W       = 3,
  parameter int DST_W       = 2,
  parameter int NSCHED      = 3,
  parameter int SID_W       = 2,
  parameter int ROB_DEPTH   = 32,
  parameter int SCHED_DEPTH = 8,
  parameter int LQ_DEPTH    = 8,
  parameter int SQ_DEPTH    = 8,
  parameter int PRF_W       = 8,
  parameter int ROBC_W      = 6,
  parameter int RGC_W       = 9,
  parameter int SCC_W       = 4,
  parameter int LQC_W       = 4,
  parameter int SQC_W       = 4,
  parameter int WW          = 3,
  parameter int SUM_W       = 5
) (
  input  logic [WW-1:0]                 eff_width,
  input  logic [PRF_W-1:0]              prf_size,
  input  logic [LANES-1:0]              valid,
  input  logic [LANES-1:0][UOP_W-1:0]   uops,
  input  logic [LANES-1:0][DST_W-1:0]   dsts,
  input  logic [LANES-1:0][SID_W-1:0]   sched,
  input  logic [LANES-1:0]              load,
  input  logic [LANES-1:0]              store,
  input  logic [LANES-1:0]              solo,
  input  logic [ROBC_W-1:0]             rob_used,
  input  logic [RGC_W-1:0]              reg_used,
  input  logic [NSCHED-1:0][SCC_W-1:0]  sch_used,
  input  logic [LQC_W-1:0]              lq_used,
  input  logic [SQC_W-1:0]              sq_used,
  output logic [LANES-1:0]              ready,
  output cause_e                        cause,
  output logic [SUM_W-1:0]              tot_uops,
  output logic [ROBC_W-1:0]             rob_take,
  output logic [RGC_W-1:0]              reg_take,
  output logic [NSCHED-1:0][SCC_W-1:0]  sch_take,
  output logic [LQC_W-1:0]              lq_take,
  output logic [SQC_W-1:0]              sq_take
);
  localparam int AW = 16;

  logic [AW-1:0]              gc, rob_a, reg_a, lq_a, sq_a, s_used, s_acc;
  logic [NSCHED-1:0][AW-1:0]  sch_a;
  logic                       stop, solo_in, hit_s;

  always_comb begin
    ready   = '0;
    cause   = CZ_NONE;
    gc      = '0;
    rob_a   = '0;
    reg_a   = '0;
    lq_a    = '0;
    sq_a    = '0;
    sch_a   = '0;
    stop    = 1'b0;
    solo_in = 1'b0;
    s_used  = '0;
    s_acc   = '0;
    hit_s   = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      s_used = '0;
      s_acc  = '0;
      hit_s  = 1'b0;
      for (int k = 0; k < NSCHED; k++) begin
        if (sched[i] == SID_W'(k)) begin
          hit_s  = 1'b1;
          s_used = AW'(sch_used[k]);
          s_acc  = sch_a[k];
        end
      end
      if (!stop) begin
        if (!valid[i]) begin
          stop = 1'b1;
        end else if (gc >= AW'(eff_width) ||
                     (gc != '0 && gc + AW'(uops[i]) > AW'(eff_width))) begin
          stop = 1'b1;                      // group full: no stall charged
        end else if (gc != '0 && (solo[i] || solo_in)) begin
          stop  = 1'b1;
          cause = CZ_GROUP;
        end else if (prf_size != '0 &&
                     AW'(reg_used) + reg_a + AW'(dsts[i]) > AW'(prf_size)) begin
          stop  = 1'b1;
          cause = CZ_REG;
        end else if (AW'(rob_used) + rob_a + AW'(uops[i]) > AW'(ROB_DEPTH)) begin
          stop  = 1'b1;
          cause = CZ_ROB;
        end else if (hit_s && s_used + s_acc + AW'(1) > AW'(SCHED_DEPTH)) begin
          stop  = 1'b1;
          cause = CZ_SCHED;
        end else if (load[i] && AW'(lq_used) + lq_a + AW'(1) > AW'(LQ_DEPTH)) begin
          stop  = 1'b1;
          cause = CZ_LQ;
        end else if (store[i] && AW'(sq_used) + sq_a + AW'(1) > AW'(SQ_DEPTH)) begin
          stop  = 1'b1;
          cause = CZ_SQ;
        end else begin
          ready[i] = 1'b1;
          gc       = gc + AW'(uops[i]);
          rob_a    = rob_a + AW'(uops[i]);
          reg_a    = reg_a + AW'(dsts[i]);
          lq_a     = lq_a + AW'(load[i]);
          sq_a     = sq_a + AW'(store[i]);
          solo_in  = solo_in | solo[i];
          for (int k = 0; k < NSCHED; k++)
            if (sched[i] == SID_W'(k)) sch_a[k] = sch_a[k] + AW'(1);
        end
      end
    end
    tot_uops = SUM_W'(gc);
    rob_take = ROBC_W'(rob_a);
    reg_take = RGC_W'(reg_a);
    lq_take  = LQC_W'(lq_a);
    sq_take  = SQC_W'(sq_a);
    for (int k = 0; k < NSCHED; k++) sch_take[k] = SCC_W'(sch_a[k]);
  end
endmodule

// File: rtl/dga_stats.sv
// Stall-reason counters and dispatch-size histogram.
module dga_stats import dga_pkg::*; #(
  parameter int DW     = 4,
  parameter int SUM_W  = 5,
  parameter int CNT_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  cause_e                        cause,
  input  logic [SUM_W-1:0]              tot_uops,
  output logic [NCAUSE-1:0][CNT_W-1:0]  stall_cnt,
  output logic [DW:0][CNT_W-1:0]        hist_cnt
);
  logic [SUM_W-1:0] bin;
  assign bin = (tot_uops > SUM_W'(DW)) ? SUM_W'(DW) : tot_uops;

  for (genvar k = 0; k < NCAUSE; k++) begin : g_stall
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   stall_cnt[k] <= '0;
      else if (cause == cause_e'(k)) stall_cnt[k] <= stall_cnt[k] + 1'b1;
    end
  end

  for (genvar b = 0; b <= DW; b++) begin : g_hist
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 hist_cnt[b] <= '0;
      else if (bin == SUM_W'(b))  hist_cnt[b] <= hist_cnt[b] + 1'b1;
    end
  end
endmodule

// File: rtl/dispatch_admit_ctrl.sv
module dispatch_admit_ctrl import dga_pkg::*; #(
  parameter int DW          = 4,
  parameter int UOP_W       = 3,
  parameter int DST_W       = 2,
  parameter int NSCHED      = 3,
  parameter int ROB_DEPTH   = 32,
  parameter int SCHED_DEPTH = 8,
  parameter int LQ_DEPTH    = 8,
  parameter int SQ_DEPTH    = 8,
  parameter int PRF_W       = 8,
  parameter int CNT_W       = 16,
  localparam int WW     = $clog2(DW + 1),
  localparam int SID_W  = (NSCHED > 1) ? $clog2(NSCHED) : 1,
  localparam int ROBC_W = $clog2(ROB_DEPTH + 1),
  localparam int RGC_W  = PRF_W + 1,
  localparam int SCC_W  = $clog2(SCHED_DEPTH + 1),
  localparam int LQC_W  = $clog2(LQ_DEPTH + 1),
  localparam int SQC_W  = $clog2(SQ_DEPTH + 1),
  localparam int SUM_W  = $clog2(DW * ((1 << UOP_W) - 1) + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [WW-1:0]                 cfg_width,
  input  logic [PRF_W-1:0]              cfg_prf_size,
  input  logic [DW-1:0]                 in_valid,
  output logic [DW-1:0]                 in_ready,
  input  logic [DW-1:0][UOP_W-1:0]      in_uops,
  input  logic [DW-1:0][DST_W-1:0]      in_dsts,
  input  logic [DW-1:0][SID_W-1:0]      in_sched,
  input  logic [DW-1:0]                 in_load,
  input  logic [DW-1:0]                 in_store,
  input  logic [DW-1:0]                 in_solo,
  input  logic [ROBC_W-1:0]             rob_ret,
  input  logic [RGC_W-1:0]              reg_ret,
  input  logic [NSCHED-1:0]             sched_ret,
  input  logic [LQC_W-1:0]              lq_ret,
  input  logic [SQC_W-1:0]              sq_ret,
  output logic [NCAUSE-1:0][CNT_W-1:0]  stall_cnt,
  output logic [DW:0][CNT_W-1:0]        hist_cnt
);
  logic [WW-1:0]                eff_width;
  logic [ROBC_W-1:0]            rob_used, rob_take;
  logic [RGC_W-1:0]             reg_used, reg_take;
  logic [LQC_W-1:0]             lq_used, lq_take;
  logic [SQC_W-1:0]             sq_used, sq_take;
  logic [NSCHED-1:0][SCC_W-1:0] sch_used, sch_take;
  cause_e                       cause;
  logic [SUM_W-1:0]             tot_uops;

  assign eff_width = (cfg_width == '0 || cfg_width > WW'(DW)) ? WW'(DW) : cfg_width;

  dga_admit #(
    .LANES(DW), .UOP_W(UOP_W), .DST_W(DST_W), .NSCHED(NSCHED), .SID_W(SID_W),
    .ROB_DEPTH(ROB_DEPTH), .SCHED_DEPTH(SCHED_DEPTH), .LQ_DEPTH(LQ_DEPTH),
    .SQ_DEPTH(SQ_DEPTH), .PRF_W(PRF_W), .ROBC_W(ROBC_W), .RGC_W(RGC_W),
    .SCC_W(SCC_W), .LQC_W(LQC_W), .SQC_W(SQC_W), .WW(WW), .SUM_W(SUM_W)
  ) u_admit (
    .eff_width(eff_width), .prf_size(cfg_prf_size), .valid(in_valid),
    .uops(in_uops), .dsts(in_dsts), .sched(in_sched), .load(in_load),
    .store(in_store), .solo(in_solo), .rob_used(rob_used), .reg_used(reg_used),
    .sch_used(sch_used), .lq_used(lq_used), .sq_used(sq_used),
    .ready(in_ready), .cause(cause), .tot_uops(tot_uops), .rob_take(rob_take),
    .reg_take(reg_take), .sch_take(sch_take), .lq_take(lq_take), .sq_take(sq_take)
  );

  dga_occ #(.W(ROBC_W)) u_rob (.clk(clk), .rst_n(rst_n), .take(rob_take), .give(rob_ret), .used(rob_used));
  dga_occ #(.W(RGC_W))  u_reg (.clk(clk), .rst_n(rst_n), .take(reg_take), .give(reg_ret), .used(reg_used));
  dga_occ #(.W(LQC_W))  u_lq  (.clk(clk), .rst_n(rst_n), .take(lq_take),  .give(lq_ret),  .used(lq_used));
  dga_occ #(.W(SQC_W))  u_sq  (.clk(clk), .rst_n(rst_n), .take(sq_take),  .give(sq_ret),  .used(sq_used));

  for (genvar k = 0; k < NSCHED; k++) begin : g_sch
    dga_occ #(.W(SCC_W)) u_sch (
      .clk(clk), .rst_n(rst_n), .take(sch_take[k]),
      .give(SCC_W'(sched_ret[k])), .used(sch_used[k])
    );
  end

  dga_stats #(.DW(DW), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_n), .cause(cause), .tot_uops(tot_uops),
    .stall_cnt(stall_cnt), .hist_cnt(hist_cnt)
  );
endmodule

// File: rtl/dga_checker.sv
module dga_checker import dga_pkg::*; #(
  parameter int DW = 4, UOP_W = 3, WW = 3, NSCHED = 3, ROB_DEPTH = 32,
  parameter int SCHED_DEPTH = 8, ROBC_W = 6, SCC_W = 4, CNT_W = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [WW-1:0]                 cfg_width,
  input logic [DW-1:0]                 in_valid,
  input logic [DW-1:0]                 in_ready,
  input logic [DW-1:0][UOP_W-1:0]      in_uops,
  input logic [ROBC_W-1:0]             rob_used,
  input logic [NSCHED-1:0][SCC_W-1:0]  sch_used,
  input logic [NCAUSE-1:0][CNT_W-1:0]  stall_cnt,
  input logic [DW:0][CNT_W-1:0]        hist_cnt
);
  logic [DW-1:0]                 fire;
  logic [15:0]                   fire_sum, lim;
  logic [CNT_W-1:0]              hsum, prev_hsum;
  logic [NCAUSE-1:0][CNT_W-1:0]  prev_stall;
  logic [NCAUSE-1:0]             moved;
  logic                          seen;

  always_comb begin
    fire     = in_valid & in_ready;
    fire_sum = '0;
    for (int i = 0; i < DW; i++) if (fire[i]) fire_sum = fire_sum + 16'(in_uops[i]);
    lim  = (cfg_width == '0 || cfg_width > WW'(DW)) ? 16'(DW) : 16'(cfg_width);
    hsum = '0;
    for (int b = 0; b <= DW; b++) hsum = hsum + hist_cnt[b];
    for (int k = 0; k < NCAUSE; k++) moved[k] = stall_cnt[k] != prev_stall[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen <= 1'b0; prev_hsum <= '0; prev_stall <= '0;
    end else begin
      seen <= 1'b1; prev_hsum <= hsum; prev_stall <= stall_cnt;
    end
  end

  assert_in_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire & (fire + DW'(1))) == '0);
  assert_group_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(fire) > 1) |-> (fire_sum <= lim));
  assert_rob_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(rob_used) <= ROB_DEPTH);
  for (genvar k = 0; k < NSCHED; k++) begin : g_sa
    assert_sched_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      32'(sch_used[k]) <= SCHED_DEPTH);
  end
  assert_one_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> $countones(moved) <= 1);
  assert_one_bin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> hsum == prev_hsum + CNT_W'(1));
endmodule

bind dispatch_admit_ctrl dga_checker #(
  .DW(DW), .UOP_W(UOP_W), .WW(WW), .NSCHED(NSCHED), .ROB_DEPTH(ROB_DEPTH),
  .SCHED_DEPTH(SCHED_DEPTH), .ROBC_W(ROBC_W), .SCC_W(SCC_W), .CNT_W(CNT_W)
) u_dga_checker (
  .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .in_valid(in_valid),
  .in_ready(in_ready), .in_uops(in_uops), .rob_used(rob_used),
  .sch_used(sch_used), .stall_cnt(stall_cnt), .hist_cnt(hist_cnt)
);

// File: tb/dispatch_admit_ctrl_bench.sv
module dispatch_admit_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int DW = 4;

  logic                 clk = 1'b0, rst_n = 1'b0;
  logic [2:0]           cfg_width;
  logic [7:0]           cfg_prf_size;
  logic [3:0]           in_valid, in_ready, in_load, in_store, in_solo;
  logic [3:0][2:0]      in_uops;
  logic [3:0][1:0]      in_dsts, in_sched;
  logic [5:0]           rob_ret;
  logic [8:0]           reg_ret;
  logic [2:0]           sched_ret;
  logic [3:0]           lq_ret, sq_ret;
  logic [5:0][15:0]     stall_cnt;
  logic [4:0][15:0]     hist_cnt;

  int total = 0, fails = 0;

  always #(CLK_P/2) clk = ~clk;

  dispatch_admit_ctrl u_dispatch_admit_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_prf_size(cfg_prf_size),
    .in_valid(in_valid), .in_ready(in_ready), .in_uops(in_uops), .in_dsts(in_dsts),
    .in_sched(in_sched), .in_load(in_load), .in_store(in_store), .in_solo(in_solo),
    .rob_ret(rob_ret), .reg_ret(reg_ret), .sched_ret(sched_ret), .lq_ret(lq_ret),
    .sq_ret(sq_ret), .stall_cnt(stall_cnt), .hist_cnt(hist_cnt)
  );

  // Stall counter indices: 0 reg, 1 rob, 2 sched, 3 lq, 4 sq, 5 group; 7 none.
  typedef struct packed {
    logic [3:0]  v;
    logic [11:0] u;     // {lane3..lane0} micro-op counts
    logic [3:0]  so;
    logic [7:0]  d;     // {lane3..lane0} destination counts
    logic [2:0]  w;
    logic [7:0]  prf;
    logic [3:0]  rdy;
    logic [2:0]  cz;
    logic [2:0]  bin;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{4'b1111, 12'h249, 4'b0000, 8'h55, 3'd0, 8'd0, 4'b1111, 3'd7, 3'd4}, // R2 full group
    '{4'b1111, 12'h252, 4'b0000, 8'h00, 3'd0, 8'd0, 4'b0011, 3'd7, 3'd4}, // R2 width reached
    '{4'b1111, 12'h249, 4'b0000, 8'h00, 3'd2, 8'd0, 4'b0011, 3'd7, 3'd2}, // R3 width 2
    '{4'b0011, 12'h249, 4'b0010, 8'h00, 3'd0, 8'd0, 4'b0001, 3'd5, 3'd1}, // R8 solo behind
    '{4'b0011, 12'h249, 4'b0001, 8'h00, 3'd0, 8'd0, 4'b0001, 3'd5, 3'd1}, // R8 solo first
    '{4'b1111, 12'h249, 4'b0000, 8'h55, 3'd0, 8'd2, 4'b0011, 3'd0, 3'd2}, // R5 register limit
    '{4'b0000, 12'h249, 4'b0000, 8'h00, 3'd0, 8'd0, 4'b0000, 3'd7, 3'd0}, // R9 empty input
    '{4'b0011, 12'h249, 4'b0000, 8'h00, 3'd0, 8'd0, 4'b0011, 3'd7, 3'd2}, // R9 input ran dry
    '{4'b0011, 12'h24B, 4'b0000, 8'h00, 3'd2, 8'd0, 4'b0001, 3'd7, 3'd3}, // R2 oversized alone
    '{4'b1111, 12'h249, 4'b0000, 8'h00, 3'd5, 8'd0, 4'b1111, 3'd7, 3'd4}, // R3 clamp above DW
    '{4'b1111, 12'h249, 4'b0000, 8'hFF, 3'd0, 8'd0, 4'b1111, 3'd7, 3'd4}, // R5 unlimited
    '{4'b1111, 12'h249, 4'b0000, 8'h09, 3'd0, 8'd3, 4'b1111, 3'd7, 3'd4}  // R5 exact fit
  };

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    in_valid = '0; in_uops = '0; in_dsts = '0; in_sched = '0;
    in_load = '0; in_store = '0; in_solo = '0;
    rob_ret = '0; reg_ret = '0; sched_ret = '0; lq_ret = '0; sq_ret = '0;
  endtask

  task automatic do_reset();
    clear_in();
    cfg_width = '0; cfg_prf_size = '0;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_lane(input int i, input int u, input int d, input int s,
                          input bit ld, input bit st);
    in_valid[i] = 1'b1; in_uops[i] = 3'(u); in_dsts[i] = 2'(d);
    in_sched[i] = 2'(s); in_load[i] = ld; in_store[i] = st;
  endtask

  // Fill n lanes; rot spreads the scheduler id over buffers 0..2.
  task automatic lanes(input int n, input int u, input int d, input bit ld,
                       input bit st, input int base, input bit rot);
    clear_in();
    for (int i = 0; i < n; i++) set_lane(i, u, d, rot ? (base + i) % 3 : base, ld, st);
  endtask

  // Check ready away from the edge, then advance one cycle.
  task automatic tick(input string tag, input logic [3:0] exp_rdy);
    #1;
    check(tag, int'(in_ready), int'(exp_rdy));
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // R12 reset state
    do_reset();
    for (int k = 0; k < 6; k++) check("R12 stall counter after reset", int'(stall_cnt[k]), 0);
    for (int b = 0; b <= DW; b++) check("R12 histogram after reset", int'(hist_cnt[b]), 0);

    // Vector table: one cycle from reset per entry.
    for (int n = 0; n < NV; n++) begin
      vec_t t;
      t = VECS[n];
      do_reset();
      cfg_width = t.w; cfg_prf_size = t.prf; in_valid = t.v; in_solo = t.so;
      for (int i = 0; i < 4; i++) begin
        in_uops[i] = t.u[3*i +: 3];
        in_dsts[i] = t.d[2*i +: 2];
      end
      tick("R1 R2 ready mask", t.rdy);
      for (int k = 0; k < 6; k++)
        check("R9 stall attribution", int'(stall_cnt[k]), (int'(t.cz) == k) ? 1 : 0);
      for (int b = 0; b <= DW; b++)
        check("R10 histogram bin", int'(hist_cnt[b]), (int'(t.bin) == b) ? 1 : 0);
    end

    // R4 reorder buffer fill, R9 priority, R11 credit timing
    do_reset();
    for (int c = 0; c < 8; c++) begin
      lanes(1, 4, 0, 0, 0, c % 2, 0);
      tick("R4 fill reorder buffer", 4'b0001);
    end
    lanes(1, 1, 0, 0, 0, 2, 0);
    tick("R4 reorder buffer full", 4'b0000);
    lanes(1, 1, 2, 0, 0, 2, 0);
    cfg_prf_size = 8'd1;
    tick("R9 register before reorder buffer", 4'b0000);
    cfg_prf_size = 8'd0;
    lanes(1, 1, 0, 0, 0, 2, 0);
    rob_ret = 6'd1;
    tick("R11 return not usable same cycle", 4'b0000);
    rob_ret = 6'd0;
    tick("R11 return usable next cycle", 4'b0001);
    check("R9 register charged once", int'(stall_cnt[0]), 1);
    check("R4 reorder buffer stalls", int'(stall_cnt[1]), 2);
    check("R10 four-uop cycles", int'(hist_cnt[4]), 8);
    check("R10 empty cycles", int'(hist_cnt[0]), 3);

    // R6 scheduler buffer full, R1 order
    do_reset();
    for (int c = 0; c < 2; c++) begin
      lanes(4, 1, 0, 0, 0, 1, 0);
      tick("R6 fill scheduler 1", 4'b1111);
    end
    clear_in();
    set_lane(0, 1, 0, 1, 0, 0);
    set_lane(1, 1, 0, 0, 0, 0);
    tick("R1 younger waits behind full scheduler", 4'b0000);
    sched_ret = 3'b010;
    tick("R11 scheduler credit same cycle", 4'b0000);
    sched_ret = 3'b000;
    tick("R6 scheduler freed", 4'b0011);
    check("R6 scheduler stalls", int'(stall_cnt[2]), 2);

    // R7 load and store queues
    do_reset();
    lanes(4, 1, 0, 1, 0, 0, 1);
    tick("R7 loads", 4'b1111);
    lanes(4, 1, 0, 1, 0, 1, 1);
    tick("R7 loads", 4'b1111);
    lanes(1, 1, 0, 1, 0, 0, 0);
    tick("R7 load queue full", 4'b0000);
    clear_in();
    set_lane(0, 1, 0, 2, 0, 1);
    set_lane(1, 1, 0, 0, 1, 0);
    tick("R7 store passes, load blocked", 4'b0001);
    lanes(4, 1, 0, 0, 1, 2, 1);
    tick("R7 stores", 4'b1111);
    lanes(3, 1, 0, 0, 1, 0, 1);
    tick("R7 stores", 4'b0111);
    lanes(1, 1, 0, 0, 1, 1, 0);
    tick("R7 store queue full", 4'b0000);
    check("R7 load queue stalls", int'(stall_cnt[3]), 2);
    check("R7 store queue stalls", int'(stall_cnt[4]), 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule